// File: doc/BRIEF.md
# Load/Store and Immediate Memory Unit

This unit carries out the memory-class operations of a small 32-bit processor against a word-addressed data memory whose read data returns one cycle after the address. For each operation it takes a 6-bit operation code, two register operand values and a 16-bit immediate field. It produces one of two results. The first is a memory request: a read for a load, or a write for a store or a store-immediate. The second is a value for register writeback, taken from memory or built from the immediate.

The caller pulses `start_i` for one cycle with the operands valid. The unit answers with a one-cycle `done_o`, and `wb_en_o`/`wb_data_o` are valid in that cycle. Non-load operations finish one cycle after start. A load finishes two cycles after start, because it waits for the memory's read data. Operand `a_i` is the value of the register named first in the instruction, and `b_i` is the value of the second. Memory addresses are the low `ADDR_W` bits of the computed sum.

Top module: `lsu_mem_unit`

## Requirements
- R1: Operation code 0x10 (load) issues a read (`mem_req_o`=1, `mem_we_o`=0) in the start cycle at address `b_i` + offset. Two cycles after start it gives `done_o`=1, `wb_en_o`=1 and `wb_data_o` equal to the memory word at that address. One cycle after start, `done_o` is 0.
- R2: Operation code 0x11 (store) issues a write in the start cycle at address `a_i` + offset with data `b_i`. `done_o`=1 and `wb_en_o`=0 one cycle after start.
- R3: Operation code 0x12 makes no memory request and writes back the immediate zero-extended to 32 bits, with done one cycle after start.
- R4: Operation code 0x14 makes no memory request and writes back the immediate shifted left by 16, with the low 16 bits zero. Done comes one cycle after start.
- R5: Operation code 0x13 writes the zero-extended immediate to memory at address `a_i`, with no offset added. There is no writeback, and done comes one cycle after start.
- R6: Operation code 0x15 writes the immediate shifted left by 16 to memory at address `a_i`. There is no writeback, and done comes one cycle after start.
- R7: For 0x10 and 0x11 the 16-bit offset is sign-extended before the add. An offset of 0xFFFE subtracts 2.
- R8: Any operation code outside 0x10 to 0x15 makes no memory request and no writeback. It gives `done_o`=1 together with `illegal_o`=1 one cycle after start.
- R9: A `start_i` that arrives while a load waits for its read data is ignored. It issues no memory request and produces no extra `done_o`.
- R10: During and after reset, with no start, `done_o`, `wb_en_o`, `illegal_o` and `mem_req_o` are 0.
- R11: The cycle in which a load reports done also accepts a new start. The new operation runs with its own normal timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle operation start |
| op_i | input | 6 | Operation code |
| a_i | input | 32 | First register operand (store base, store-immediate address) |
| b_i | input | 32 | Second register operand (load base, store data) |
| imm_i | input | 16 | Offset or immediate |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after a read request |
| done_o | output | 1 | Operation complete (one cycle) |
| wb_en_o | output | 1 | Register writeback valid |
| wb_data_o | output | 32 | Register writeback value |
| illegal_o | output | 1 | Operation code not supported |

## Verification
Two functions can meet in one cycle: the completion of a load, and the acceptance of the next operation. The bench provokes this by starting a load-immediate in the very cycle the load reports done. It judges that cycle by the load's writeback value. It judges the next cycle by the new operation's constant. A start presented during the load's wait cycle is judged at the ports. No memory request may appear in that cycle, and no extra done may follow. Reading back the targeted word must show it unchanged.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [5:0] {
    OP_LOAD = 6'h10,
    OP_STORE = 6'h11,
    OP_LD_LO = 6'h12,
    OP_ST_LO = 6'h13,
    OP_LD_HI = 6'h14,
    OP_ST_HI = 6'h15
  } lsu_op_e;

  typedef struct packed {
    logic legal;
    logic is_load;
    logic mem_wr;
    logic reg_wr;
    logic use_off;
    logic upper;
  } lsu_ctl_t;

  typedef enum logic {S_IDLE, S_LOAD_WAIT} lsu_state_e;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
(
  input  logic [5:0] op_i,
  output lsu_ctl_t   ctl_o
);
  always_comb begin
    ctl_o = '0;
    case (op_i)
      OP_LOAD:  begin ctl_o.legal = 1'b1; ctl_o.is_load = 1'b1; ctl_o.reg_wr = 1'b1; ctl_o.use_off = 1'b1; end
      OP_STORE: begin ctl_o.legal = 1'b1; ctl_o.mem_wr = 1'b1; ctl_o.use_off = 1'b1; end
      OP_LD_LO: begin ctl_o.legal = 1'b1; ctl_o.reg_wr = 1'b1; end
      OP_ST_LO: begin ctl_o.legal = 1'b1; ctl_o.mem_wr = 1'b1; end
      OP_LD_HI: begin ctl_o.legal = 1'b1; ctl_o.reg_wr = 1'b1; ctl_o.upper = 1'b1; end
      OP_ST_HI: begin ctl_o.legal = 1'b1; ctl_o.mem_wr = 1'b1; ctl_o.upper = 1'b1; end
      default:  ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              is_load_i,
  input  logic              use_off_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] offset;
  logic [DATA_W-1:0] sum;
  logic              unused_hi;

  always_comb begin
    base   = is_load_i ? b_i : a_i;
    offset = use_off_i ? {{EXT_W{imm_i[IMM_W-1]}}, imm_i} : '0;
    sum    = base + offset;
  end

  assign addr_o    = sum[ADDR_W-1:0];
  assign unused_hi = ^sum[DATA_W-1:ADDR_W];
endmodule

// File: rtl/lsu_immgen.sv
module lsu_immgen #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              upper_i,
  output logic [DATA_W-1:0] val_o
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] lo_val;

  assign lo_val = {{PAD_W{1'b0}}, imm_i};
  assign val_o  = upper_i ? (lo_val << IMM_W) : lo_val;
endmodule

// File: rtl/lsu_seq.sv
module lsu_seq
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              legal_i,
  input  logic              is_load_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] imm_val_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              accept_o,
  output logic              done_o,
  output logic              wb_en_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              illegal_o
);
  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  lsu_state_e        st_q, st_n;
  logic              done_q, done_n;
  logic              wben_q, wben_n;
  logic              ill_q, ill_n;
  logic              wbd_en;
  logic [DATA_W-1:0] wbd_q, wbd_n;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign accept_o = start_i && core_rst_n && (st_q == S_IDLE);

  always_comb begin
    st_n   = st_q;
    done_n = 1'b0;
    wben_n = 1'b0;
    ill_n  = 1'b0;
    wbd_en = 1'b0;
    wbd_n  = rdata_i;
    case (st_q)
      S_IDLE: begin
        if (accept_o) begin
          if (is_load_i) begin
            st_n = S_LOAD_WAIT;
          end else begin
            done_n = 1'b1;
            ill_n  = !legal_i;
            wben_n = reg_wr_i;
            wbd_en = reg_wr_i;
            wbd_n  = imm_val_i;
          end
        end
      end
      S_LOAD_WAIT: begin
        st_n   = S_IDLE;
        done_n = 1'b1;
        wben_n = 1'b1;
        wbd_en = 1'b1;
        wbd_n  = rdata_i;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      st_q   <= S_IDLE;
      done_q <= 1'b0;
      wben_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= done_n;
      wben_q <= wben_n;
      ill_q  <= ill_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wbd_en) wbd_q <= wbd_n;
  end

  assign done_o    = done_q;
  assign wb_en_o   = wben_q;
  assign illegal_o = ill_q;
  assign wb_data_o = wbd_q;
endmodule

// File: rtl/lsu_mem_unit.sv
module lsu_mem_unit
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int IMM_W  = 16,
  parameter int OP_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              wb_en_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              illegal_o
);
  lsu_ctl_t          ctl;
  logic [DATA_W-1:0] imm_val;
  logic              accept;

  lsu_decode u_dec (
    .op_i  (op_i),
    .ctl_o (ctl)
  );

  lsu_agen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_agen (
    .a_i       (a_i),
    .b_i       (b_i),
    .imm_i     (imm_i),
    .is_load_i (ctl.is_load),
    .use_off_i (ctl.use_off),
    .addr_o    (mem_addr_o)
  );

  lsu_immgen #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_imm (
    .imm_i   (imm_i),
    .upper_i (ctl.upper),
    .val_o   (imm_val)
  );

  lsu_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .legal_i   (ctl.legal),
    .is_load_i (ctl.is_load),
    .reg_wr_i  (ctl.reg_wr),
    .imm_val_i (imm_val),
    .rdata_i   (mem_rdata_i),
    .accept_o  (accept),
    .done_o    (done_o),
    .wb_en_o   (wb_en_o),
    .wb_data_o (wb_data_o),
    .illegal_o (illegal_o)
  );

  assign mem_req_o   = accept && ctl.legal && (ctl.is_load || ctl.mem_wr);
  assign mem_we_o    = accept && ctl.legal && ctl.mem_wr;
  assign mem_wdata_o = ctl.use_off ? b_i : imm_val;
endmodule

// File: rtl/lsu_mem_unit_chk.sv
module lsu_mem_unit_chk #(
  parameter int DATA_W = 32,
  parameter int OP_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [OP_W-1:0]   op_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic              done_o,
  input logic              wb_en_o,
  input logic [DATA_W-1:0] wb_data_o,
  input logic              illegal_o
);
  logic op_ok;
  assign op_ok = (op_i >= OP_W'(6'h10)) && (op_i <= OP_W'(6'h15));

  assert_req_needs_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> start_i);

  assert_load_timing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |=> (!done_o ##1 (done_o && wb_en_o && !illegal_o)));

  assert_load_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |=> ##1 (wb_data_o == $past(mem_rdata_i)));

  assert_write_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> (done_o && !wb_en_o && !illegal_o));

  assert_write_is_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_req_o);

  assert_illegal_no_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !op_ok) |-> !mem_req_o);

  assert_illegal_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (done_o && !wb_en_o));

  assert_wb_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> done_o);
endmodule

bind lsu_mem_unit lsu_mem_unit_chk #(.DATA_W(DATA_W), .OP_W(OP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .op_i        (op_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_rdata_i (mem_rdata_i),
  .done_o      (done_o),
  .wb_en_o     (wb_en_o),
  .wb_data_o   (wb_data_o),
  .illegal_o   (illegal_o)
);

// File: tb/tb_lsu_mem_unit.sv
`timescale 1ns/1ps
module tb_lsu_mem_unit;
  localparam int DW = 32;
  localparam int AW = 8;

  logic          clk, rst_n, start;
  logic [5:0]    op;
  logic [DW-1:0] a, b;
  logic [15:0]   imm;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          done, wb_en, illegal;
  logic [DW-1:0] wb_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [DW-1:0] mem [0:(1<<AW)-1];

  lsu_mem_unit dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
    .imm_i(imm), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .done_o(done),
    .wb_en_o(wb_en), .wb_data_o(wb_data), .illegal_o(illegal)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_req && mem_we)  mem[mem_addr] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
  end

  // kind: 0 load, 1 memory write, 2 register immediate, 3 illegal
  typedef struct packed {
    logic [5:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] imm;
    logic [1:0]  kind;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] wb;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [0:NV-1] = '{
    '{6'h10, 32'h0,      32'h20,       16'h0005, 2'd0, 8'h25, 32'h0,        32'hA5000025, 8'd1}, // R1
    '{6'h10, 32'h0,      32'h30,       16'hFFFE, 2'd0, 8'h2E, 32'h0,        32'hA500002E, 8'd7}, // R7
    '{6'h11, 32'h40,     32'hDEADBEEF, 16'h0003, 2'd1, 8'h43, 32'hDEADBEEF, 32'h0,        8'd2}, // R2
    '{6'h11, 32'h50,     32'h12345678, 16'hFFFF, 2'd1, 8'h4F, 32'h12345678, 32'h0,        8'd7}, // R7
    '{6'h12, 32'h0,      32'h0,        16'hBEEF, 2'd2, 8'h00, 32'h0,        32'h0000BEEF, 8'd3}, // R3
    '{6'h14, 32'h0,      32'h0,        16'h1234, 2'd2, 8'h00, 32'h0,        32'h12340000, 8'd4}, // R4
    '{6'h13, 32'h60,     32'h0,        16'h8001, 2'd1, 8'h60, 32'h00008001, 32'h0,        8'd5}, // R5
    '{6'h15, 32'h161,    32'h0,        16'hABCD, 2'd1, 8'h61, 32'hABCD0000, 32'h0,        8'd6}, // R6
    '{6'h16, 32'h10,     32'h10,       16'h0001, 2'd3, 8'h00, 32'h0,        32'h0,        8'd8}, // R8
    '{6'h00, 32'h10,     32'h10,       16'h0001, 2'd3, 8'h00, 32'h0,        32'h0,        8'd8}, // R8
    '{6'h10, 32'h0,      32'h43,       16'h0000, 2'd0, 8'h43, 32'h0,        32'hDEADBEEF, 8'd2}, // R2 readback
    '{6'h10, 32'h0,      32'h61,       16'h0000, 2'd0, 8'h61, 32'h0,        32'hABCD0000, 8'd6}  // R6 readback
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input vec_t v);
    string t;
    bit exp_req, exp_we, exp_wb;
    t = $sformatf("R%0d", v.req);
    exp_req = (v.kind <= 2'd1);
    exp_we  = (v.kind == 2'd1);
    exp_wb  = (v.kind == 2'd0) || (v.kind == 2'd2);
    @(negedge clk);
    start = 1; op = v.op; a = v.a; b = v.b; imm = v.imm;
    #1;
    chk(mem_req == exp_req, {t, " mem_req"}, 32'(mem_req), 32'(exp_req));
    if (exp_req) begin
      chk(mem_we == exp_we, {t, " mem_we"}, 32'(mem_we), 32'(exp_we));
      chk(mem_addr == v.addr, {t, " addr"}, 32'(mem_addr), 32'(v.addr));
    end
    if (exp_we) chk(mem_wdata == v.wdata, {t, " wdata"}, mem_wdata, v.wdata);
    @(negedge clk);
    start = 0;
    if (v.kind == 2'd0) begin
      chk(done == 1'b0, {t, " early done"}, 32'(done), 32'h0);
      @(negedge clk);
    end
    chk(done == 1'b1, {t, " done"}, 32'(done), 32'h1);
    chk(wb_en == exp_wb, {t, " wb_en"}, 32'(wb_en), 32'(exp_wb));
    if (exp_wb) chk(wb_data == v.wb, {t, " wb_data"}, wb_data, v.wb);
    chk(illegal == (v.kind == 2'd3), {t, " illegal"}, 32'(illegal), 32'(v.kind == 2'd3));
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 32'hA5000000 | i;
    start = 0; op = 0; a = 0; b = 0; imm = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!done && !wb_en && !illegal && !mem_req, "R10 in reset", {done, wb_en, illegal, mem_req}, 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!done && !wb_en && !illegal && !mem_req, "R10 after reset", {done, wb_en, illegal, mem_req}, 32'h0);

    for (int k = 0; k < NV; k++) run_op(VECS[k]);

    // R9: start during load wait is ignored
    @(negedge clk);
    start = 1; op = 6'h10; b = 32'h70; imm = 16'h0;
    @(negedge clk);
    op = 6'h11; a = 32'h70; b = 32'h11111111;
    #1;
    chk(mem_req == 1'b0, "R9 req while busy", 32'(mem_req), 32'h0);
    @(negedge clk);
    start = 0;
    chk(done && wb_en && wb_data == 32'hA5000070, "R9 load result", wb_data, 32'hA5000070);
    @(negedge clk);
    chk(done == 1'b0, "R9 no extra done", 32'(done), 32'h0);
    run_op('{6'h10, 32'h0, 32'h70, 16'h0, 2'd0, 8'h70, 32'h0, 32'hA5000070, 8'd9}); // R9 word unchanged

    // R11: new start in the cycle a load completes
    @(negedge clk);
    start = 1; op = 6'h10; b = 32'h25; imm = 16'h0;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    start = 1; op = 6'h12; imm = 16'h7777;
    #1;
    chk(done && wb_en && wb_data == 32'hA5000025, "R11 load done", wb_data, 32'hA5000025);
    chk(mem_req == 1'b0, "R11 no req for imm", 32'(mem_req), 32'h0);
    @(negedge clk);
    start = 0;
    chk(done && wb_en && wb_data == 32'h00007777, "R11 following op", wb_data, 32'h00007777);
    @(negedge clk);
    chk(done == 1'b0, "R11 quiet after", 32'(done), 32'h0);

    report();
  end
endmodule